// File: doc/BRIEF.md
# CHS Sector Address Sequencer

This block keeps the cylinder, head and sector address and the count of sectors still to go while a disk controller moves a run of sectors. Software stages six start bytes. A start pulse copies them into the working registers and opens a transfer. The data path then sends one strobe per byte moved. After each full sector of bytes, the block steps to the next sector, rolling the sector over into the head and the head over into the cylinder. Those rollovers happen at limits taken from a separate geometry (specify) command. Each step also lowers the remaining count.

For every address the block presents a registered linear block address, computed from the drive's head count. At the end of a transfer it offers a seven-byte result record through a byte-select read port. The cylinder high byte travels in complemented form in both the start bytes and the result record. A byte strobe that arrives when no sectors remain ends the transfer with an overrun code.

Top module: `chs_sector_sequencer`

## Requirements
- R1: After reset, `active` and `done` are 0, `lba` is 0, and every result byte reads 0 except byte 2, which reads 0xFF (the complemented cylinder high byte of cylinder 0).
- R2: A write with `prm_we` stages byte `prm_idx`, using this index order: 0 physical head, 1 complemented cylinder high, 2 cylinder low, 3 head, 4 sector, 5 sector count. Writes to indexes 6 and 7 change nothing. `xfer_start` copies all six staged bytes into the working state and sets `active`.
- R3: A write with `spec_we` sets the ending track from index 3 and the ending sector from index 4; other indexes are ignored. After reset the ending sector is SECT_PER_TRACK-1 (17) and the ending track is 0.
- R4: After every SECTOR_BYTES byte strobes of an active transfer, the address advances. If the old sector was at or above the ending sector, the sector becomes 0 and the head steps; otherwise the sector increments.
- R5: When the head steps from a value at or above the ending track, it becomes 0 and the 16-bit cylinder increments, so a cylinder low byte of 0xFF carries into the high byte.
- R6: `lba` equals (18·heads·cylinder + 18·head + sector) mod 2^24 and follows an address or `heads` change one clock later.
- R7: Each completed sector lowers the count by one. When the count reaches 0, `active` falls, `done` pulses for one cycle, and the end status is 0x00.
- R8: A byte strobe while `active` with a count of 0 ends the transfer: `done` pulses, the end status becomes 0x10, and address and count stay unchanged.
- R9: Result byte `res_idx` reads 0 end status, 1 physical head, 2 complemented cylinder high, 3 cylinder low, 4 head, 5 sector, 6 remaining count; index 7 reads 0.
- R10: A byte strobe in the same cycle as `xfer_start`, or while not `active`, is not counted.
- R11: Staging writes made during a transfer leave the working address and count untouched until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prm_we | input | 1 | Start-byte staging write |
| prm_idx | input | 3 | Start-byte index |
| prm_data | input | 8 | Start-byte value |
| spec_we | input | 1 | Geometry (specify) byte write |
| spec_idx | input | 3 | Geometry byte index |
| spec_data | input | 8 | Geometry byte value |
| heads | input | 4 | Head count of the selected drive |
| xfer_start | input | 1 | Load staged bytes and open a transfer |
| byte_stb | input | 1 | One byte moved by the data path |
| res_idx | input | 3 | Result byte select |
| res_byte | output | 8 | Selected result byte |
| lba | output | 24 | Linear block address of the current sector |
| active | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two pairs of events can fall in one clock. In the first, a start pulse and a byte strobe arrive together. The bench drives both in a single cycle on a one-sector transfer, then counts the further strobes needed before `done` appears; one strobe fewer than a full sector would show the strobe was counted. In the second, the last byte of a sector is also the last byte of the transfer, so the address step, the count reaching zero and the end pulse all land in one cycle. This is judged by reading the stepped address and a zero count in the same cycle that `done` is seen.

// File: rtl/chs_seq_pkg.sv
// Shared constants and types for the CHS sector address sequencer.
// Assumes byte-wide parameter and result paths.
package chs_seq_pkg;
    localparam int PRM_BYTES = 6;
    localparam logic [2:0] SPEC_TRK_IDX = 3'd3;
    localparam logic [2:0] SPEC_SEC_IDX = 3'd4;
    localparam logic [7:0] ST_OK      = 8'h00;
    localparam logic [7:0] ST_OVERRUN = 8'h10;

    // Decoded start set, cylinder high held in true form
    typedef struct packed {
        logic [7:0] phys_head;
        logic [7:0] cyl_hi;
        logic [7:0] cyl_lo;
        logic [7:0] head;
        logic [7:0] sector;
        logic [7:0] count;
    } start_set_t;
endpackage

// File: rtl/chs_param_stage.sv
// Holds the six staged start bytes and the two geometry limits.
// Assumes index 1 arrives complemented; it is restored to true form here.
module chs_param_stage
    import chs_seq_pkg::*;
#(
    parameter int SECT_PER_TRACK = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prm_we,
    input  logic [2:0] prm_idx,
    input  logic [7:0] prm_data,
    input  logic       spec_we,
    input  logic [2:0] spec_idx,
    input  logic [7:0] spec_data,
    output start_set_t start_set,
    output logic [7:0] sec_end,
    output logic [7:0] trk_end
);
    localparam logic [7:0] SEC_END_RST = 8'(SECT_PER_TRACK - 1);

    logic [7:0] stg_q [PRM_BYTES];

    genvar g;
    generate
        for (g = 0; g < PRM_BYTES; g++) begin : g_stg
            // Capture one staged byte when its index is written
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg_q[g] <= 8'h00;
                else if (prm_we && prm_idx == 3'(g))
                    stg_q[g] <= prm_data;
            end
        end
    endgenerate

    // Capture the ending sector and ending track from the geometry command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_end <= SEC_END_RST;
            trk_end <= 8'h00;
        end else if (spec_we) begin
            if (spec_idx == SPEC_SEC_IDX) sec_end <= spec_data;
            if (spec_idx == SPEC_TRK_IDX) trk_end <= spec_data;
        end
    end

    // Decode the staged bytes into the start set
    always_comb begin
        start_set.phys_head = stg_q[0];
        start_set.cyl_hi    = ~stg_q[1];
        start_set.cyl_lo    = stg_q[2];
        start_set.head      = stg_q[3];
        start_set.sector    = stg_q[4];
        start_set.count     = stg_q[5];
    end
endmodule

// File: rtl/chs_addr_counter.sv
// Working cylinder/head/sector register with limit-based rollover.
// Assumes load has priority over advance.
module chs_addr_counter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] ld_cyl,
    input  logic [7:0]  ld_head,
    input  logic [7:0]  ld_sector,
    input  logic        adv,
    input  logic [7:0]  sec_end,
    input  logic [7:0]  trk_end,
    output logic [15:0] cyl,
    output logic [7:0]  head,
    output logic [7:0]  sector
);
    // Load the start address or step to the next sector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl    <= 16'h0000;
            head   <= 8'h00;
            sector <= 8'h00;
        end else if (load) begin
            cyl    <= ld_cyl;
            head   <= ld_head;
            sector <= ld_sector;
        end else if (adv) begin
            if (sector >= sec_end) begin
                sector <= 8'h00;
                if (head >= trk_end) begin
                    head <= 8'h00;
                    cyl  <= cyl + 16'd1;
                end else begin
                    head <= head + 8'd1;
                end
            end else begin
                sector <= sector + 8'd1;
            end
        end
    end
endmodule

// File: rtl/chs_lba_calc.sv
// Registered linear block address from cylinder, head, sector and head count.
// Assumes a fixed sectors-per-track figure; result truncates to LBA_W bits.
module chs_lba_calc #(
    parameter int SECT_PER_TRACK = 18,
    parameter int HEADS_W        = 4,
    parameter int LBA_W          = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HEADS_W-1:0] heads,
    input  logic [15:0]        cyl,
    input  logic [7:0]         head,
    input  logic [7:0]         sector,
    output logic [LBA_W-1:0]   lba
);
    localparam logic [31:0] SPT = 32'(SECT_PER_TRACK);

    logic [31:0] per_cyl;
    logic [31:0] full;

    // Sum the cylinder, track and sector contributions
    always_comb begin
        per_cyl = SPT * 32'(heads);
        full    = per_cyl * 32'(cyl) + SPT * 32'(head) + 32'(sector);
    end

    // Register the address to cut the multiplier path
    always_ff @(posedge clk) begin
        if (!rst_n) lba <= '0;
        else        lba <= full[LBA_W-1:0];
    end
endmodule

// File: rtl/chs_sector_sequencer.sv
// Top of the CHS sector address sequencer: byte counting, sector count,
// end status and result record. Assumes one byte_stb per byte moved.
module chs_sector_sequencer
    import chs_seq_pkg::*;
#(
    parameter int SECTOR_BYTES   = 512,
    parameter int SECT_PER_TRACK = 18,
    parameter int HEADS_W        = 4,
    parameter int LBA_W          = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prm_we,
    input  logic [2:0]         prm_idx,
    input  logic [7:0]         prm_data,
    input  logic               spec_we,
    input  logic [2:0]         spec_idx,
    input  logic [7:0]         spec_data,
    input  logic [HEADS_W-1:0] heads,
    input  logic               xfer_start,
    input  logic               byte_stb,
    input  logic [2:0]         res_idx,
    output logic [7:0]         res_byte,
    output logic [LBA_W-1:0]   lba,
    output logic               active,
    output logic               done
);
    localparam int          BC_W    = $clog2(SECTOR_BYTES);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(SECTOR_BYTES - 1);

    start_set_t      start_set;
    logic [7:0]      sec_end, trk_end;
    logic [15:0]     cyl;
    logic [7:0]      head, sector;
    logic [7:0]      phys_head_q, sec_cnt_q, end_status_q;
    logic [BC_W-1:0] bcnt_q;
    logic            stb_ok, sect_end, adv;

    chs_param_stage #(.SECT_PER_TRACK(SECT_PER_TRACK)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .prm_we(prm_we), .prm_idx(prm_idx), .prm_data(prm_data),
        .spec_we(spec_we), .spec_idx(spec_idx), .spec_data(spec_data),
        .start_set(start_set), .sec_end(sec_end), .trk_end(trk_end)
    );

    chs_addr_counter u_addr (
        .clk(clk), .rst_n(rst_n), .load(xfer_start),
        .ld_cyl({start_set.cyl_hi, start_set.cyl_lo}),
        .ld_head(start_set.head), .ld_sector(start_set.sector),
        .adv(adv), .sec_end(sec_end), .trk_end(trk_end),
        .cyl(cyl), .head(head), .sector(sector)
    );

    chs_lba_calc #(
        .SECT_PER_TRACK(SECT_PER_TRACK), .HEADS_W(HEADS_W), .LBA_W(LBA_W)
    ) u_lba (
        .clk(clk), .rst_n(rst_n), .heads(heads),
        .cyl(cyl), .head(head), .sector(sector), .lba(lba)
    );

    // Qualify strobes: only while active and not in a start cycle
    always_comb begin
        stb_ok   = active && byte_stb && !xfer_start;
        sect_end = stb_ok && (sec_cnt_q != 8'h00) && (bcnt_q == BC_LAST);
        adv      = sect_end;
    end

    // Transfer control: start, byte count, sector count, end status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            done         <= 1'b0;
            phys_head_q  <= 8'h00;
            sec_cnt_q    <= 8'h00;
            end_status_q <= ST_OK;
            bcnt_q       <= '0;
        end else begin
            done <= 1'b0;
            if (xfer_start) begin
                active       <= 1'b1;
                phys_head_q  <= start_set.phys_head;
                sec_cnt_q    <= start_set.count;
                end_status_q <= ST_OK;
                bcnt_q       <= '0;
            end else if (stb_ok) begin
                if (sec_cnt_q == 8'h00) begin
                    active       <= 1'b0;
                    done         <= 1'b1;
                    end_status_q <= ST_OVERRUN;
                end else if (bcnt_q == BC_LAST) begin
                    bcnt_q    <= '0;
                    sec_cnt_q <= sec_cnt_q - 8'd1;
                    if (sec_cnt_q == 8'd1) begin
                        active       <= 1'b0;
                        done         <= 1'b1;
                        end_status_q <= ST_OK;
                    end
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
        end
    end

    // Select one byte of the result record
    always_comb begin
        case (res_idx)
            3'd0:    res_byte = end_status_q;
            3'd1:    res_byte = phys_head_q;
            3'd2:    res_byte = ~cyl[15:8];
            3'd3:    res_byte = cyl[7:0];
            3'd4:    res_byte = head;
            3'd5:    res_byte = sector;
            3'd6:    res_byte = sec_cnt_q;
            default: res_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/chs_seq_checker.sv
// Protocol checks for the CHS sector address sequencer, bound to the top.
// Assumes the reset is synchronous and active low.
module chs_seq_checker
    import chs_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_start,
    input logic       byte_stb,
    input logic       active,
    input logic       done,
    input logic [7:0] end_status,
    input logic [7:0] sec_cnt,
    input logic [7:0] sector
);
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(active)); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |=> (sec_cnt == $past(sec_cnt) || sec_cnt == $past(sec_cnt) - 8'd1)); // R7
    AST_OVERRUN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && end_status != ST_OK) |-> end_status == ST_OVERRUN); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !xfer_start) |=> ($stable(sec_cnt) && $stable(sector))); // R10
    AST_SECTOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_start && byte_stb) |=> (sector == $past(sector) || sector == $past(sector) + 8'd1 || sector == 8'h00)); // R4
endmodule

bind chs_sector_sequencer chs_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .byte_stb(byte_stb),
    .active(active), .done(done), .end_status(end_status_q),
    .sec_cnt(sec_cnt_q), .sector(sector)
);

// File: tb/tb_chs_sector_sequencer.sv
module tb_chs_sector_sequencer;
    localparam int SB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prm_we = 1'b0, spec_we = 1'b0, xfer_start = 1'b0, byte_stb = 1'b0;
    logic [2:0] prm_idx = '0, spec_idx = '0, res_idx = '0;
    logic [7:0] prm_data = '0, spec_data = '0;
    logic [3:0] heads = 4'd9;
    logic [7:0] res_byte;
    logic [23:0] lba;
    logic       active, done;

    int nvec = 0, nmis = 0;
    int m_cyl, m_head, m_sec, m_cnt, m_phys, m_esn, m_etn;

    chs_sector_sequencer #(.SECTOR_BYTES(SB)) dut (
        .clk(clk), .rst_n(rst_n), .prm_we(prm_we), .prm_idx(prm_idx),
        .prm_data(prm_data), .spec_we(spec_we), .spec_idx(spec_idx),
        .spec_data(spec_data), .heads(heads), .xfer_start(xfer_start),
        .byte_stb(byte_stb), .res_idx(res_idx), .res_byte(res_byte),
        .lba(lba), .active(active), .done(done)
    );

    always #10 clk = ~clk;

    initial begin
        #4000000;
        nmis++;
        $display("FAIL watchdog: run did not finish (got hang, expected end)");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    task automatic chk(string tag, int got, int exp);
        nvec++;
        if (got != exp) begin
            nmis++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic rd(input int idx, output int v);
        res_idx = 3'(idx);
        #1;
        v = int'(res_byte);
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_prm(int idx, int val);
        prm_we = 1'b1; prm_idx = 3'(idx); prm_data = 8'(val);
        @(negedge clk);
        prm_we = 1'b0;
    endtask

    task automatic wr_spec(int idx, int val);
        spec_we = 1'b1; spec_idx = 3'(idx); spec_data = 8'(val);
        @(negedge clk);
        spec_we = 1'b0;
    endtask

    task automatic start_x();
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic stb(int n);
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1;
            @(negedge clk);
        end
        byte_stb = 1'b0;
    endtask

    task automatic load(int phys, int cylv, int hd, int sc, int cnt);
        wr_prm(0, phys);
        wr_prm(1, ~(cylv >> 8) & 8'hFF);
        wr_prm(2, cylv & 8'hFF);
        wr_prm(3, hd);
        wr_prm(4, sc);
        wr_prm(5, cnt);
        m_phys = phys; m_cyl = cylv; m_head = hd; m_sec = sc; m_cnt = cnt;
    endtask

    // Requirement model of one address step
    task automatic model_adv();
        if (m_sec >= m_esn) begin
            m_sec = 0;
            if (m_head >= m_etn) begin
                m_head = 0;
                m_cyl  = (m_cyl + 1) & 16'hFFFF;
            end else m_head = m_head + 1;
        end else m_sec = m_sec + 1;
    endtask

    task automatic chk_rec(string tag, int status);
        int v;
        rd(0, v); chk({tag, " status"}, v, status);
        rd(1, v); chk({tag, " phys head"}, v, m_phys);
        rd(2, v); chk({tag, " cyl hi n"}, v, ~(m_cyl >> 8) & 8'hFF);
        rd(3, v); chk({tag, " cyl lo"}, v, m_cyl & 8'hFF);
        rd(4, v); chk({tag, " head"}, v, m_head);
        rd(5, v); chk({tag, " sector"}, v, m_sec);
        rd(6, v); chk({tag, " count"}, v, m_cnt);
    endtask

    function automatic int exp_lba();
        longint t;
        t = 64'd18 * longint'(heads) * longint'(m_cyl) + 64'd18 * longint'(m_head) + longint'(m_sec);
        return int'(t % 64'd16777216);
    endfunction

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 active", int'(active), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 lba", int'(lba), 0);
        for (int i = 0; i < 8; i++) begin
            rd(i, v);
            chk("R1 result byte", v, (i == 2) ? 8'hFF : 0);
        end

        // R3 reset limits: sector end 17, track end 0
        m_esn = 17; m_etn = 0;
        load(1, 16'h0041, 0, 17, 1);
        start_x();
        chk("R2 active after start", int'(active), 1);
        chk_rec("R2 start", 0);
        stb(SB);
        model_adv(); m_cnt = 0;
        chk("R3 R7 done", int'(done), 1);
        chk_rec("R3 reset limits", 0);

        // R3 program limits; other indexes ignored
        wr_spec(4, 2);
        wr_spec(3, 1);
        wr_spec(0, 0);
        wr_spec(1, 0);
        wr_spec(2, 0);
        wr_spec(5, 0);
        m_esn = 2; m_etn = 1;

        // R4 R5 R6 R7 sweep across cylinder carry for two head counts
        for (int hp = 0; hp < 2; hp++) begin
            heads = (hp == 0) ? 4'd3 : 4'd15;
            load(5 + hp, 16'h00FE, 0, 0, 14);
            start_x();
            cyc(1);
            chk("R6 start lba", int'(lba), exp_lba());
            for (int s = 0; s < 14; s++) begin
                if (s % 3 == 1) begin
                    stb(1); cyc(2); stb(SB - 1);
                end else stb(SB);
                model_adv(); m_cnt = m_cnt - 1;
                chk("R7 done", int'(done), (m_cnt == 0) ? 1 : 0);
                chk("R7 active", int'(active), (m_cnt == 0) ? 0 : 1);
                chk_rec("R4 R5 sweep", 0);
                cyc(1);
                chk("R6 lba", int'(lba), exp_lba());
                chk("R7 done single", int'(done), 0);
            end
        end

        // R6 truncation at the top cylinder
        heads = 4'd15;
        load(0, 16'hFFFF, 1, 2, 1);
        start_x();
        cyc(1);
        chk("R6 lba truncated", int'(lba), exp_lba());
        // R5 cylinder wraps to zero
        stb(SB);
        model_adv(); m_cnt = 0;
        chk_rec("R5 top wrap", 0);

        // R10 strobe with start not counted; strobes while idle ignored
        load(2, 16'h0010, 0, 0, 1);
        xfer_start = 1'b1; byte_stb = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0; byte_stb = 1'b0;
        stb(SB - 1);
        chk("R10 no early done", int'(done), 0);
        chk("R10 still active", int'(active), 1);
        stb(1);
        model_adv(); m_cnt = 0;
        chk("R10 done after full sector", int'(done), 1);
        stb(SB + 1);
        chk("R10 idle strobes", int'(done), 0);
        chk_rec("R10 idle record", 0);

        // R8 overrun with zero count
        load(3, 16'h0123, 1, 1, 0);
        start_x();
        stb(1);
        chk("R8 done", int'(done), 1);
        chk("R8 active", int'(active), 0);
        chk_rec("R8 overrun", 8'h10);

        // R11 staging during a transfer; R2 writes to index 6 and 7 ignored
        load(4, 16'h0200, 0, 0, 3);
        start_x();
        wr_prm(4, 1);
        wr_prm(6, 8'hAA);
        wr_prm(7, 8'h55);
        stb(SB);
        model_adv(); m_cnt = 2;
        chk_rec("R11 working untouched", 0);
        m_cyl = 16'h0200; m_head = 0; m_sec = 1; m_cnt = 3; m_phys = 4;
        start_x();
        chk_rec("R2 restart staged", 0);
        rd(7, v);
        chk("R9 index 7", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule